// File: doc/BRIEF.md
# Instruction-Boundary Interrupt Recognizer

This block sits next to a processor core's sequencer. At the end of every instruction it decides whether the core should enter an interrupt, and of which kind. Two request sources exist. A general request is active-high and level-sensitive, and software can gate it with an interrupt-enable flag. The urgent request cannot be gated. It is built from a coprocessor interrupt line and a memory parity error. The parity error only counts while its own enable is set.

The urgent source is edge-detected. A low-to-high transition is held in a pending latch until a boundary services it, so a brief pulse that falls between boundaries is still taken. When both kinds are present at a boundary, the urgent one is taken first as interrupt type 2. A general request whose level is still held is then taken at a later boundary. For a general request, the block tells the core to run an external acknowledge sequence, which supplies the type number. The vector-table fetch and the acknowledge bus cycle are handled elsewhere.

All decisions are registered. The outputs appear in the cycle after the clock edge that sampled the instruction-complete pulse. The asynchronous active-low reset is released to the logic through a synchronizer.

Top module: `irq_boundary_recognizer`

## Requirements
- R1: While reset is asserted, and after it is released, `take_o`, `ext_ack_o` and `vec_type_o` read 0. Reset also discards any pending urgent request, so a boundary right after release takes nothing.
- R2: `take_o` pulses only in the cycle after a clock edge at which `instr_done_i` was 1. With no boundary, nothing is taken and pending requests wait.
- R3: The urgent source is `copro_irq_i | (parity_err_i & parity_nmi_en_i)`. A parity error while the enable is 0 produces no take.
- R4: A rising edge of the urgent source becomes pending. It stays pending after the source returns low, and the next boundary takes it. An edge first seen at the same clock edge as a boundary is taken at the following boundary.
- R5: An urgent take drives `vec_type_o` = 2 and `ext_ack_o` = 0.
- R6: An urgent request is taken whether `if_flag_i` is 1 or 0.
- R7: At a boundary with no urgent request pending, `intr_i`=1 and `if_flag_i`=1 give a take with `ext_ack_o`=1 and `vec_type_o`=0.
- R8: While `if_flag_i` is 0, `intr_i` has no effect: no take happens at the boundary.
- R9: When an urgent request is pending and `intr_i` is enabled at the same boundary, the urgent request is taken. The general request is taken at the next boundary if its level is still held.
- R10: Taking an urgent request clears it. A source held high produces no second take.
- R11: A source that is already high when reset is released is not counted as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| instr_done_i | input | 1 | Pulse in the last cycle of each instruction (boundary) |
| intr_i | input | 1 | Level-sensitive general interrupt request |
| if_flag_i | input | 1 | Software interrupt-enable flag |
| copro_irq_i | input | 1 | Coprocessor interrupt, urgent source |
| parity_err_i | input | 1 | Memory parity error |
| parity_nmi_en_i | input | 1 | Lets the parity error reach the urgent source |
| take_o | output | 1 | One-cycle pulse: enter an interrupt |
| ext_ack_o | output | 1 | Type must come from an external acknowledge sequence |
| vec_type_o | output | VEC_W | Interrupt type for an internal take (2), else 0 |

## Verification
Properties checked on every cycle:
- a take never appears without a preceding boundary;
- an internal take always carries type 2;
- an acknowledged take always had the enable flag and the request high one cycle earlier;
- a pending urgent request at a boundary always wins;
- a serviced edge is always cleared.

Some behaviours only the bench's scenarios can show:
- a short pulse survives until the next boundary;
- an edge that coincides with a boundary is deferred;
- a general request that loses arbitration is taken one boundary later;
- a source that is high through reset release, or reset in mid-pending, leaves nothing to take.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int unsigned DEF_VEC_W   = 8;
  localparam int unsigned DEF_NMI_VEC = 2;
  localparam int unsigned DEF_RST_STG = 2;

  typedef enum logic [1:0] {
    SRC_NONE     = 2'd0,
    SRC_URGENT   = 2'd1,
    SRC_MASKABLE = 2'd2
  } irq_src_e;
endpackage

// File: rtl/irq_rst_sync.sv
`timescale 1ns/1ps
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_urgent_latch.sv
`timescale 1ns/1ps
module irq_urgent_latch (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic copro_irq_i,
  input  logic parity_err_i,
  input  logic parity_nmi_en_i,
  input  logic service_i,
  output logic pending_o
);
  logic src;
  logic src_q, src_d;
  logic rise;
  logic pend_q, pend_d;

  // Combined unmaskable source (R3)
  always_comb begin
    src = copro_irq_i | (parity_err_i & parity_nmi_en_i);
  end

  // Edge detect and hold-until-serviced (R4, R10); new edge beats clear
  always_comb begin
    rise   = src & ~src_q;
    src_d  = src;
    pend_d = rise | (pend_q & ~service_i);
  end

  // src_q resets high so a level present at release is not an edge (R11)
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      src_q  <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      src_q  <= src_d;
      pend_q <= pend_d;
    end
  end

  assign pending_o = pend_q;

  a_r10_cleared_on_service: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ($past(service_i) && !$past(rise)) |-> !pend_q);

  a_r4_edge_latched: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    rise |=> pend_q);
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int unsigned VEC_W   = DEF_VEC_W,
  parameter int unsigned NMI_VEC = DEF_NMI_VEC
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             instr_done_i,
  input  logic             urgent_pend_i,
  input  logic             intr_i,
  input  logic             if_flag_i,
  output logic             service_o,
  output logic             take_o,
  output logic             ext_ack_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam logic [VEC_W-1:0] URGENT_CODE = VEC_W'(NMI_VEC);

  irq_src_e         sel;
  logic             take_q, take_d;
  logic             ack_q, ack_d;
  logic [VEC_W-1:0] vec_q, vec_d;

  // Boundary decision: urgent first, then flag-gated level (R2, R8, R9)
  always_comb begin
    sel = SRC_NONE;
    if (instr_done_i) begin
      if (urgent_pend_i)            sel = SRC_URGENT;
      else if (intr_i && if_flag_i) sel = SRC_MASKABLE;
    end
  end

  always_comb begin
    take_d = (sel != SRC_NONE);
    ack_d  = (sel == SRC_MASKABLE);
    vec_d  = (sel == SRC_URGENT) ? URGENT_CODE : '0;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      take_q <= 1'b0;
      ack_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      take_q <= take_d;
      ack_q  <= ack_d;
      vec_q  <= vec_d;
    end
  end

  assign service_o = (sel == SRC_URGENT);
  assign take_o    = take_q;
  assign ext_ack_o = ack_q;
  assign vec_o     = vec_q;

  a_r2_take_needs_boundary: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    take_q |-> $past(instr_done_i));

  a_r5_urgent_code: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (take_q && !ack_q) |-> (vec_q == URGENT_CODE));

  a_r7_ack_zero_type: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ack_q |-> (take_q && vec_q == '0));

  a_r8_flag_gates_level: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (take_q && ack_q) |-> $past(if_flag_i && intr_i));

  a_r9_urgent_wins: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (instr_done_i && urgent_pend_i) |=> (take_q && !ack_q));
endmodule

// File: rtl/irq_boundary_recognizer.sv
`timescale 1ns/1ps
module irq_boundary_recognizer
  import irq_pkg::*;
#(
  parameter int unsigned VEC_W      = DEF_VEC_W,
  parameter int unsigned NMI_VEC    = DEF_NMI_VEC,
  parameter int unsigned RST_STAGES = DEF_RST_STG
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             instr_done_i,
  input  logic             intr_i,
  input  logic             if_flag_i,
  input  logic             copro_irq_i,
  input  logic             parity_err_i,
  input  logic             parity_nmi_en_i,
  output logic             take_o,
  output logic             ext_ack_o,
  output logic [VEC_W-1:0] vec_type_o
);
  logic rst_int_n;
  logic urgent_pend;
  logic service;

  irq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_int_n)
  );

  irq_urgent_latch u_urgent (
    .clk_i           (clk_i),
    .rst_n_i         (rst_int_n),
    .copro_irq_i     (copro_irq_i),
    .parity_err_i    (parity_err_i),
    .parity_nmi_en_i (parity_nmi_en_i),
    .service_i       (service),
    .pending_o       (urgent_pend)
  );

  irq_arbiter #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_arb (
    .clk_i         (clk_i),
    .rst_n_i       (rst_int_n),
    .instr_done_i  (instr_done_i),
    .urgent_pend_i (urgent_pend),
    .intr_i        (intr_i),
    .if_flag_i     (if_flag_i),
    .service_o     (service),
    .take_o        (take_o),
    .ext_ack_o     (ext_ack_o),
    .vec_o         (vec_type_o)
  );

  a_r1_quiet_in_reset: assert property (@(posedge clk_i)
    !rst_int_n |-> (!take_o && !ext_ack_o && vec_type_o == '0));
endmodule

// File: tb/test_irq_boundary_recognizer.sv
`timescale 1ns/1ps
module test_irq_boundary_recognizer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       done, intr, ifl, cop, par, pen;
  logic       take, ack;
  logic [7:0] vec;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  irq_boundary_recognizer i_irq_boundary_recognizer (
    .clk_i(clk), .rst_n_i(rst_n), .instr_done_i(done), .intr_i(intr),
    .if_flag_i(ifl), .copro_irq_i(cop), .parity_err_i(par),
    .parity_nmi_en_i(pen), .take_o(take), .ext_ack_o(ack), .vec_type_o(vec)
  );

  // {intr, if, copro, parity, par_en, done, exp_take, exp_ack, exp_vec}
  localparam int NROWS = 17;
  localparam logic [15:0] ROWS [NROWS] = '{
    {6'b000000, 2'b00, 8'd0},  // R2 idle
    {6'b110000, 2'b00, 8'd0},  // R2 request, no boundary
    {6'b110001, 2'b11, 8'd0},  // R7 enabled level taken
    {6'b100001, 2'b00, 8'd0},  // R8 flag clear
    {6'b001000, 2'b00, 8'd0},  // R4 edge latched
    {6'b000000, 2'b00, 8'd0},  // R4 pulse gone
    {6'b000001, 2'b10, 8'd2},  // R6 taken with flag clear
    {6'b000001, 2'b00, 8'd0},  // R10 cleared
    {6'b000100, 2'b00, 8'd0},  // R3 parity, enable off
    {6'b000101, 2'b00, 8'd0},  // R3 no take
    {6'b000110, 2'b00, 8'd0},  // R3 enabled parity edge
    {6'b110111, 2'b10, 8'd2},  // R9 urgent wins
    {6'b110111, 2'b11, 8'd0},  // R9 level follows, R10 no retake
    {6'b000000, 2'b00, 8'd0},  // R10 release
    {6'b001001, 2'b00, 8'd0},  // R4 edge at boundary deferred
    {6'b001001, 2'b10, 8'd2},  // R5 urgent type
    {6'b000000, 2'b00, 8'd0}   // R2 idle
  };
  string row_req [NROWS] = '{"R2","R2","R7","R8","R4","R4","R6","R10","R3",
                             "R3","R3","R9","R9","R10","R4","R5","R2"};

  task automatic check(input string req, input logic et, input logic ea,
                       input logic [7:0] ev);
    n_run++;
    if (take !== et || ack !== ea || vec !== ev) begin
      n_fail++;
      $display("FAIL %s: take=%b ack=%b vec=%0d expected take=%b ack=%b vec=%0d",
               req, take, ack, vec, et, ea, ev);
    end
  endtask

  task automatic drive(input logic [5:0] v);
    {intr, ifl, cop, par, pen, done} = v;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung");
    finish_run();
  end

  initial begin
    drive(6'b0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", 1'b0, 1'b0, 8'd0);           // R1 during reset
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 1'b0, 1'b0, 8'd0);           // R1 after release

    for (int i = 0; i < NROWS; i++) begin
      drive(ROWS[i][15:10]);
      @(negedge clk);
      check(row_req[i], ROWS[i][9], ROWS[i][8], ROWS[i][7:0]);
    end

    // R11: source held high across reset release is not an edge
    drive(6'b001000);
    do_reset();
    drive(6'b001001);
    @(negedge clk);
    check("R11", 1'b0, 1'b0, 8'd0);
    drive(6'b001001);
    @(negedge clk);
    check("R11", 1'b0, 1'b0, 8'd0);

    // R1: reset discards a pending urgent request
    drive(6'b000000);
    @(negedge clk);
    drive(6'b000010);
    drive(6'b001000);
    @(negedge clk);
    drive(6'b000000);
    do_reset();
    drive(6'b000001);
    @(negedge clk);
    check("R1", 1'b0, 1'b0, 8'd0);

    // R4: short pulse survives several idle cycles
    drive(6'b000110);
    @(negedge clk);
    drive(6'b000000);
    repeat (5) @(negedge clk);
    check("R2", 1'b0, 1'b0, 8'd0);
    drive(6'b000001);
    @(negedge clk);
    check("R4", 1'b1, 1'b0, 8'd2);
    drive(6'b000000);
    @(negedge clk);
    check("R2", 1'b0, 1'b0, 8'd0);

    finish_run();
  end
endmodule